// File: doc/BRIEF.md
# Bidirectional Loadable Shift Register

This block is a width-parameterised storage register that can be cleared at once, loaded in parallel, held, or shifted by one place in either direction. Each direction has its own serial input. A sequential add-and-shift multiplier uses two of these blocks as its accumulator and multiplier storage. The same block also works as a plain register with an enable: drive the load input and leave the shift enable low.

Clear has the highest priority and does not wait for a clock. Load comes next, then shift enable. With shift enable low and no load, the register keeps its value. The direction input only has an effect while a shift is taking place.

Top module: `bishift_reg`

## Requirements
- R1: While `clr_a` is 1, `q` is all zeros at once, without waiting for a clock edge, and it stays zero until `clr_a` returns to 0.
- R2: With `clr_a` at 0, `q` changes only on a rising edge of `clk`.
- R3: On a rising edge with `load` = 1, `q` takes the value of `din`, whatever `shift_en` and `go_left` are.
- R4: On a rising edge with `load` = 0 and `shift_en` = 0, `q` keeps its value.
- R5: On a rising edge with `load` = 0, `shift_en` = 1 and `go_left` = 0, `q` becomes `{ser_right, q[W-1:1]}`. `ser_right` enters at the MSB.
- R6: On a rising edge with `load` = 0, `shift_en` = 1 and `go_left` = 1, `q` becomes `{q[W-2:0], ser_left}`. `ser_left` enters at the LSB.
- R7: `ser_left` has no effect on a right shift, and `ser_right` has no effect on a left shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr_a | input | 1 | Asynchronous clear, active high |
| load | input | 1 | Parallel load request |
| shift_en | input | 1 | Shift enable; when low, the register holds |
| go_left | input | 1 | Direction: 1 shifts left, 0 shifts right |
| ser_left | input | 1 | Serial input that enters at the LSB on a left shift |
| ser_right | input | 1 | Serial input that enters at the MSB on a right shift |
| din | input | W | Parallel load data |
| q | output | W | Register contents |

## Verification
The hardest case to reach is a clear that arrives between clock edges and is then released, still between edges. The bench raises `clr_a` in the middle of the clock's low phase while the register holds a nonzero value. It checks that `q` is zero before the next edge arrives, and that the edges that follow keep `q` at zero while clear is held. The bench also drives the unused serial input to the opposite value on every shift, so a swapped serial input shows up in the result.

// File: rtl/bishift_pkg.sv
package bishift_pkg;
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_RIGHT = 2'd2,
        OP_LEFT  = 2'd3
    } bishift_op_e;
endpackage

// File: rtl/bishift_decode.sv
module bishift_decode
    import bishift_pkg::*;
(
    input  logic        load,
    input  logic        shift_en,
    input  logic        go_left,
    output bishift_op_e op
);
    always_comb begin
        if (load)          op = OP_LOAD;
        else if (!shift_en) op = OP_HOLD;
        else if (go_left)   op = OP_LEFT;
        else                op = OP_RIGHT;
    end
endmodule

// File: rtl/bishift_reg.sv
module bishift_reg
    import bishift_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_a,
    input  logic         load,
    input  logic         shift_en,
    input  logic         go_left,
    input  logic         ser_left,
    input  logic         ser_right,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] data;
    } state_t;

    state_t      st_d, st_q;
    bishift_op_e op;

    initial begin
        if (W < 2) $error("bishift_reg: W must be at least 2");
    end

    bishift_decode u_dec (
        .load     (load),
        .shift_en (shift_en),
        .go_left  (go_left),
        .op       (op)
    );

    always_comb begin
        st_d = st_q;
        unique case (op)
            OP_LOAD:  st_d.data = din;
            OP_RIGHT: st_d.data = {ser_right, st_q.data[MSB:1]};
            OP_LEFT:  st_d.data = {st_q.data[MSB-1:0], ser_left};
            default:  st_d.data = st_q.data;
        endcase
    end

    always_ff @(posedge clk or posedge clr_a) begin
        if (clr_a) st_q <= '0;
        else       st_q <= st_d;
    end

    assign q = st_q.data;

    // R1: clear forces zero
    p_clear_zero_r1: assert property (@(posedge clk) clr_a |-> q == '0);

    // R3: load takes din
    p_load_r3: assert property (@(posedge clk) disable iff (clr_a)
        load |=> q == $past(din));

    // R4: hold
    p_hold_r4: assert property (@(posedge clk) disable iff (clr_a)
        (!load && !shift_en) |=> $stable(q));

    // R5: right shift
    p_right_r5: assert property (@(posedge clk) disable iff (clr_a)
        (!load && shift_en && !go_left) |=>
        q == {$past(ser_right), $past(q[MSB:1])});

    // R6: left shift
    p_left_r6: assert property (@(posedge clk) disable iff (clr_a)
        (!load && shift_en && go_left) |=>
        q == {$past(q[MSB-1:0]), $past(ser_left)});
endmodule

// File: tb/bishift_reg_test.sv
module bishift_reg_test;
    localparam int  W = 4;
    localparam time TCLK = 10ns;

    logic         clk = 0, clr_a = 1, load = 0, shift_en = 0, go_left = 0;
    logic         ser_left = 0, ser_right = 0;
    logic [W-1:0] din = '0;
    logic [W-1:0] q;
    logic [W-1:0] model = '0;
    int           errors = 0, checks = 0;
    logic [W-1:0] expq[$];
    string        tagq[$];
    logic         done = 0;

    bishift_reg #(.W(W)) uut (
        .clk(clk), .clr_a(clr_a), .load(load), .shift_en(shift_en),
        .go_left(go_left), .ser_left(ser_left), .ser_right(ser_right),
        .din(din), .q(q)
    );

    always #(TCLK/2) clk = ~clk;

    task automatic check_now(logic [W-1:0] exp, string tag);
        checks++;
        if (q !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected=%b", tag, q, exp);
        end
    endtask

    // Monitor: each edge that has a queued item gets compared 2ns later
    always @(posedge clk) begin
        if (expq.size() > 0) begin
            logic [W-1:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            #2 check_now(e, t);
        end
    end

    // Driver: apply one op at negedge, compute expected, push
    task automatic op(logic l, logic ce, logic lf, logic sl, logic sr,
                      logic [W-1:0] d, string tag);
        @(negedge clk);
        load = l; shift_en = ce; go_left = lf;
        ser_left = sl; ser_right = sr; din = d;
        if (l)        model = d;
        else if (!ce) model = model;
        else if (lf)  model = {model[W-2:0], sl};
        else          model = {sr, model[W-1:1]};
        expq.push_back(model);
        tagq.push_back(tag);
    endtask

    initial begin
        #(TCLK*2000);
        errors++; checks++;
        $display("FAIL watchdog: q=%b expected=done", q);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #3ns check_now('0, "R1 reset");
        @(negedge clk); @(negedge clk);
        check_now('0, "R1 held across edges");
        clr_a = 0;
        op(1, 1, 1, 1, 1, 4'b1011, "R3 load ignores ce/left");
        op(0, 0, 1, 1, 1, 4'b0000, "R4 hold");
        op(0, 0, 0, 0, 1, 4'b1111, "R4 hold din ignored");
        op(0, 1, 0, 1, 0, 4'b0000, "R5/R7 right sr=0 sl=1");
        op(0, 1, 0, 0, 1, 4'b0000, "R5/R7 right sr=1 sl=0");
        op(0, 1, 1, 0, 1, 4'b0000, "R6/R7 left sl=0 sr=1");
        op(0, 1, 1, 1, 0, 4'b0000, "R6/R7 left sl=1 sr=0");
        op(1, 0, 0, 0, 0, 4'b0110, "R3 load plain");
        for (int i = 0; i < 6; i++)
            op(0, 1, i[0], i[1], ~i[1], 4'b1001, "R5/R6 mixed");
        op(0, 0, 0, 0, 0, 4'b0000, "R4 final hold");
        @(negedge clk);
        // R2: mid-cycle input change without edge keeps q
        din = 4'b0101; load = 1;
        #1 check_now(model, "R2 no edge no change");
        load = 0; shift_en = 0;
        // R1: async clear mid-phase
        #1 clr_a = 1;
        #1 check_now('0, "R1 async clear mid-cycle");
        model = '0;
        load = 1; din = 4'b1111;
        @(negedge clk);
        check_now('0, "R1 clear beats load");
        clr_a = 0; load = 0;
        @(negedge clk);
        check_now('0, "R4 hold after clear");
        op(1, 0, 0, 0, 0, 4'b1010, "R3 load after clear");
        @(negedge clk); @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule